// File: doc/BRIEF.md
# Synchronous Decade Counter with Registered One-of-Ten Decode

This block counts from 0 to 9 in BCD and gives a one-of-ten decode of the count. Both the count and the decode come straight from flip-flops. All of those flip-flops share one clock edge, so no output can show a decoding glitch. The decoded lines are safe to use where a spurious pulse would cause harm, for example as a strobe or as a clear condition in another block.

The decode register does not decode the current count. It loads the decode of the next count value. Because of this, the ten lines always agree with the count in the same cycle and never lag it by a cycle. A count enable decides whether the counter advances. A synchronous reset returns the block to zero. A terminal-count flag marks the cycle in which an enabled edge will wrap the counter from 9 back to 0.

Top module: `sync_decade_decoder`

## Requirements
- R1: While reset is high at a rising clock edge, the block loads count 0000 and the decoded lines 10'b1111111110, where bit i of the line bus is line i and only line 0 is low.
- R2: On a rising edge with reset low and enable high, a count below 9 increases by exactly one.
- R3: On a rising edge with reset low, enable high and count 9, the count becomes 0. On that same edge the low line moves from line 9 to line 0.
- R4: In every cycle after reset, exactly one decoded line is low, and its index equals the count value. There is no cycle of lag between count and lines.
- R5: On a rising edge with reset low and enable low, the count and all ten decoded lines keep their values.
- R6: Reset takes priority over enable. With both high, the block loads the reset state of R1.
- R7: The terminal-count output is high exactly when the count is 9 and enable is high. When it is high and reset is low, the next edge brings the count to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock; every flip-flop uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable, active high |
| count | output | 4 | Registered BCD count value |
| line_n | output | 10 | Registered active-low decode; bit i is low when count is i |
| tc | output | 1 | High when count is 9 and enable is high |

## Verification
The in-module assertions check on every cycle that exactly one line is low and that it matches the count. They also check the step by one, the wrap after 9, the hold when enable is low, the reset state, and that terminal count is followed by zero. The bench's scenarios are needed for the rest. They show that reset overrides an active enable, that long idle stretches keep the state, and that three full laps through all ten values follow the expected sequence at the ports.

// File: rtl/sync_decade_decoder.sv
module sync_decade_decoder (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output logic [3:0] count,
  output logic [9:0] line_n,
  output logic       tc
);
  localparam logic [3:0] LAST_VAL   = 4'd9;
  localparam logic [9:0] ZERO_LINES = 10'b11_1111_1110;

  function automatic logic [9:0] decode_n(input logic [3:0] v);
    decode_n = '1;
    for (int i = 0; i < 10; i++)
      if (v == 4'(i)) decode_n[i] = 1'b0;
  endfunction

  logic [3:0] cnt_q, cnt_next;
  logic [9:0] lines_q;
  logic       at_last;

  assign at_last  = (cnt_q == LAST_VAL);
  assign cnt_next = at_last ? 4'd0 : cnt_q + 4'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= 4'd0;
      lines_q <= ZERO_LINES;
    end else if (en) begin
      cnt_q   <= cnt_next;
      lines_q <= decode_n(cnt_next);
    end
  end

  assign count  = cnt_q;
  assign line_n = lines_q;
  assign tc     = en & at_last;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (count == 4'd0 && line_n == ZERO_LINES));

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (en && count < LAST_VAL) |=> count == 4'($past(count) + 4'd1));

  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (en && count == LAST_VAL) |=> (count == 4'd0 && line_n == ZERO_LINES));

  a_r4_aligned: assert property (@(posedge clk) disable iff (rst)
    (count <= LAST_VAL) && ($countones(~line_n) == 1) && !line_n[count]);

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(count) && $stable(line_n)));

  a_r7_tc_wraps: assert property (@(posedge clk) disable iff (rst)
    tc |=> count == 4'd0);
endmodule

// File: tb/sync_decade_decoder_tb.sv
module sync_decade_decoder_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [3:0] count;
  logic [9:0] line_n;
  logic tc;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sync_decade_decoder u_dut (
    .clk(clk), .rst(rst), .en(en),
    .count(count), .line_n(line_n), .tc(tc)
  );

  // vector: {rst, en, expected count[3:0], expected tc}
  localparam int NV = 15;
  localparam logic [6:0] VEC [NV] = '{
    {2'b11, 4'd0, 1'b0},
    {2'b01, 4'd1, 1'b0}, {2'b01, 4'd2, 1'b0}, {2'b01, 4'd3, 1'b0},
    {2'b01, 4'd4, 1'b0}, {2'b01, 4'd5, 1'b0}, {2'b01, 4'd6, 1'b0},
    {2'b01, 4'd7, 1'b0}, {2'b01, 4'd8, 1'b0}, {2'b01, 4'd9, 1'b1},
    {2'b01, 4'd0, 1'b0}, {2'b00, 4'd0, 1'b0}, {2'b01, 4'd1, 1'b0},
    {2'b00, 4'd1, 1'b0}, {2'b11, 4'd0, 1'b0}
  };

  function automatic logic [9:0] exp_lines(input logic [3:0] v);
    exp_lines = ~(10'd1 << v);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic e);
    @(negedge clk);
    rst = r; en = e;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [3:0] model;
    step(1'b1, 1'b0);
    chk("R1 reset count", 16'(count), 16'd0);
    chk("R1 reset lines", 16'(line_n), 16'h3FE);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][6], VEC[i][5]);
      chk("R2/R3/R5/R6 vector count", 16'(count), 16'(VEC[i][4:1]));
      chk("R4 vector lines", 16'(line_n), 16'(exp_lines(VEC[i][4:1])));
      chk("R7 vector tc", 16'(tc), 16'(VEC[i][0]));
    end

    // R5: long idle at count 5
    step(1'b0, 1'b1); step(1'b0, 1'b1); step(1'b0, 1'b1);
    step(1'b0, 1'b1); step(1'b0, 1'b1);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0);
    chk("R5 idle count", 16'(count), 16'd5);
    chk("R5 idle lines", 16'(line_n), 16'(exp_lines(4'd5)));
    chk("R7 tc low when idle", 16'(tc), 16'd0);

    // R2/R3/R4: three laps
    model = 4'd5;
    for (int i = 0; i < 30; i++) begin
      step(1'b0, 1'b1);
      model = (model == 4'd9) ? 4'd0 : model + 4'd1;
      chk("R2/R3 lap count", 16'(count), 16'(model));
      chk("R4 lap lines", 16'(line_n), 16'(exp_lines(model)));
      chk("R7 lap tc", 16'(tc), 16'(model == 4'd9));
    end

    // R7: tc follows enable while sitting at 9
    while (count != 4'd9) step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    chk("R7 tc low at 9 with en low", 16'(tc), 16'd0);
    en = 1'b1; #1;
    chk("R7 tc high at 9 with en high", 16'(tc), 16'd1);

    // R6: reset beats enable at count 9
    step(1'b1, 1'b1);
    chk("R6 reset priority count", 16'(count), 16'd0);
    chk("R6 reset priority lines", 16'(line_n), 16'h3FE);
    step(1'b0, 1'b1);
    chk("R1 count after release", 16'(count), 16'd1);
    finish_run();
  end
endmodule